// File: doc/BRIEF.md
# Polarity-Configurable Event Flag Aggregator

This block collects a set of event sources into a register of sticky flags. Each source passes through its own polarity inversion before it is captured. A source is wired as one of two kinds, chosen per bit by a build parameter:

- **Edge kind:** the flag sets once, on the rising edge of the post-polarity signal.
- **Level kind:** the flag keeps setting for as long as the post-polarity signal is high.

Once a flag is set, it stays set until software clears it. There are two ways to clear a flag:

- write a 1 to its bit in a clear register;
- write a 0 to its bit in the flag register itself.

A level flag whose source is still active sets again at once, so it can only be cleared after its source has gone away. Software may also set any flag through a set register. The meaning of flags set this way is left to software.

A mask register picks which flags feed a combined level output. That output is high while any selected flag is set. It would normally feed a wake-up or interrupt path in another domain. Crossing into that domain is left to the receiver.

The register bus is a simple single-cycle write port with a combinational read. The address map is:

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | flags | write-0-to-clear | flags |
| 1 | clear | write-1-to-clear | 0 |
| 2 | set | write-1-to-set | 0 |
| 3 | polarity | read/write | polarity |
| 4 | mask | read/write | mask |

Top module: `evf_top`

## Requirements
- R1: When polarity bit i is 1, source i is inverted before capture. A source held low then behaves as active, and a falling source edge counts as an active edge.
- R2: A bus write to address 1 clears every flag whose data bit is 1. The clear is visible after the next rising clock edge. Reads of address 1 return 0.
- R3: A bus write to address 0 clears every flag whose data bit is 0.
- R4: A level-kind flag (bits 4 to 7 by default) cannot be cleared while its post-polarity source is high. It can be cleared once the source is low.
- R5: `comb_o` is high exactly when some flag is set whose bit in the mask register (address 4) is also 1.
- R6: A bus write to address 2 sets every flag whose data bit is 1. Reads of address 2 return 0.
- R7: An edge-kind flag (bits 0 to 3 by default) sets once per rising edge of the post-polarity source. After it is cleared, it stays clear while the source is held.
- R8: If a hardware set and a bus clear hit the same flag in the same cycle, the flag ends up set.
- R9: Writing 1 to a bit of the flag register (address 0) does not set that flag.
- R10: After reset, all flags, polarity bits and mask bits are 0. `comb_o` is 0.
- R11: The polarity and mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | N | Event sources, synchronous to clk |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | N | Write data |
| bus_rdata_o | output | N | Read data for bus_addr_i |
| flags_o | output | N | Sticky flags towards the destination domain |
| comb_o | output | 1 | OR of the mask-selected flags |

## Verification
The assertions assume that `src_i` is already synchronous to `clk`. They also assume that the bus never writes to addresses 5 to 7. Their clear and set checks exclude any bit that hardware raises in the same cycle, so they rely on the internal hardware-set vector being a faithful one-cycle view of the sources. The stimulus changes sources and bus signals only on falling clock edges. It uses only mapped addresses, and it arranges each polarity change so that the stimulus decides whether the change creates an edge.

// File: rtl/evf_pkg.sv
`timescale 1ns/1ps
package evf_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_FLAGS = 3'd0,
        A_CLR   = 3'd1,
        A_SET   = 3'd2,
        A_POL   = 3'd3,
        A_MASK  = 3'd4
    } evf_addr_e;
endpackage

// File: rtl/evf_capture.sv
`timescale 1ns/1ps
module evf_capture #(
    parameter int          N         = 8,
    parameter logic [N-1:0] LEVEL_SRC = 8'hF0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] hw_set_o
);
    logic [N-1:0] act;

    assign act = src_i ^ pol_i;

    for (genvar i = 0; i < N; i++) begin : g_src
        if (LEVEL_SRC[i]) begin : g_level
            assign hw_set_o[i] = act[i];
        end else begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= act[i];
            end
            assign hw_set_o[i] = act[i] & ~prev_q;
        end
    end
endmodule

// File: rtl/evf_cfg.sv
`timescale 1ns/1ps
module evf_cfg
    import evf_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    output logic [N-1:0]      pol_o,
    output logic [N-1:0]      mask_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_o  <= '0;
            mask_o <= '0;
        end else if (wr_i) begin
            if (addr_i == A_POL)  pol_o  <= wdata_i;
            if (addr_i == A_MASK) mask_o <= wdata_i;
        end
    end
endmodule

// File: rtl/evf_flags.sv
`timescale 1ns/1ps
module evf_flags
    import evf_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [N-1:0]      wdata_i,
    input  logic [N-1:0]      hw_set_i,
    output logic [N-1:0]      flags_o
);
    logic [N-1:0] clr_vec;
    logic [N-1:0] sw_set;
    logic [N-1:0] flags_n;

    always_comb begin
        clr_vec = '0;
        sw_set  = '0;
        if (wr_i) begin
            unique case (addr_i)
                A_FLAGS: clr_vec = ~wdata_i;
                A_CLR:   clr_vec = wdata_i;
                A_SET:   sw_set  = wdata_i;
                default: ;
            endcase
        end
        // set has priority over clear
        flags_n = (flags_o & ~clr_vec) | hw_set_i | sw_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= flags_n;
    end
endmodule

// File: rtl/evf_top.sv
`timescale 1ns/1ps
module evf_top
    import evf_pkg::*;
#(
    parameter int           N         = 8,
    parameter logic [N-1:0] LEVEL_SRC = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      src_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [N-1:0]      bus_wdata_i,
    output logic [N-1:0]      bus_rdata_o,
    output logic [N-1:0]      flags_o,
    output logic              comb_o
);
    logic [N-1:0] pol;
    logic [N-1:0] mask;
    logic [N-1:0] hw_set;

    evf_cfg #(.N(N)) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .pol_o(pol), .mask_o(mask)
    );

    evf_capture #(.N(N), .LEVEL_SRC(LEVEL_SRC)) cap_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .pol_i(pol), .hw_set_o(hw_set)
    );

    evf_flags #(.N(N)) flg_i (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .hw_set_i(hw_set), .flags_o(flags_o)
    );

    always_comb begin
        unique case (bus_addr_i)
            A_FLAGS: bus_rdata_o = flags_o;
            A_POL:   bus_rdata_o = pol;
            A_MASK:  bus_rdata_o = mask;
            default: bus_rdata_o = '0;
        endcase
    end

    assign comb_o = |(flags_o & mask);
endmodule

// File: rtl/evf_chk.sv
`timescale 1ns/1ps
module evf_chk
    import evf_pkg::*;
#(
    parameter int N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [N-1:0]      wdata,
    input logic [N-1:0]      hw_set,
    input logic [N-1:0]      flags,
    input logic              comb
);
    AST_CLR_REG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CLR) |=> ((flags & $past(wdata & ~hw_set)) == '0)); // R2

    AST_FLAG_W0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_FLAGS) |=> ((flags & $past(~wdata & ~hw_set)) == '0)); // R3

    AST_FLAG_W1_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_FLAGS) |=> ((flags & ~$past(flags | hw_set)) == '0)); // R9

    AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_SET) |=> (($past(wdata) & ~flags) == '0)); // R6

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set != '0) |=> (($past(hw_set) & ~flags) == '0)); // R8

    AST_COMB_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        comb |-> (flags != '0)); // R5
endmodule

bind evf_top evf_chk #(.N(N)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .hw_set(hw_set), .flags(flags_o), .comb(comb_o)
);

// File: tb/evf_top_tb_top.sv
`timescale 1ns/1ps
module evf_top_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic         wr = 1'b0;
    logic [2:0]   addr = 3'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic [N-1:0] flags;
    logic         comb;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evf_top #(.N(N), .LEVEL_SRC(8'hF0)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .flags_o(flags), .comb_o(comb)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write takes effect at the posedge between the two negedges
    task automatic bus_write(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; addr = 3'd0; wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [N-1:0] d);
        addr = a;
        #0.5;
        d = rdata;
        addr = 3'd0;
    endtask

    task automatic set_src(input int b, input logic v);
        @(negedge clk);
        src[b] = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [N-1:0] d;
        check("R10 flags", flags, 8'h00);
        check("R10 comb", {7'd0, comb}, 8'h00);
        bus_read(3'd3, d); check("R10 pol", d, 8'h00);
        bus_read(3'd4, d); check("R10 mask", d, 8'h00);
    endtask

    task automatic t_edge();
        logic [N-1:0] d;
        set_src(0, 1'b1);
        check("R7 edge sets", flags, 8'h01);
        bus_write(3'd1, 8'h01);
        check("R2 clear reg", flags, 8'h00);
        bus_read(3'd1, d); check("R2 clear reads 0", d, 8'h00);
        @(negedge clk); @(negedge clk);
        check("R7 held source no reset", flags, 8'h00);
        set_src(0, 1'b0);
        check("R7 falling no set", flags, 8'h00);
    endtask

    task automatic t_level();
        set_src(4, 1'b1);
        check("R4 level sets", flags, 8'h10);
        bus_write(3'd1, 8'h10);
        check("R4 clear blocked", flags, 8'h10);
        set_src(4, 1'b0);
        check("R4 sticky after release", flags, 8'h10);
        bus_write(3'd1, 8'h10);
        check("R4 clear after release", flags, 8'h00);
    endtask

    task automatic t_pol();
        logic [N-1:0] d;
        set_src(1, 1'b1);
        bus_write(3'd1, 8'h02);
        bus_write(3'd3, 8'h02);
        check("R1 inverted fall no edge yet", flags, 8'h00);
        bus_read(3'd3, d); check("R11 pol readback", d, 8'h02);
        set_src(1, 1'b0);
        check("R1 falling edge sets", flags, 8'h02);
        bus_write(3'd3, 8'h22);
        @(negedge clk);
        check("R1 inverted low level sets", flags, 8'h22);
        bus_write(3'd3, 8'h00);
        bus_write(3'd0, 8'hDD);
        check("R3 write zero clears", flags, 8'h00);
    endtask

    task automatic t_swset();
        logic [N-1:0] d;
        bus_write(3'd2, 8'h0C);
        check("R6 sw set", flags, 8'h0C);
        bus_read(3'd2, d); check("R6 set reads 0", d, 8'h00);
        bus_write(3'd0, 8'hFF);
        check("R9 write one no set", flags, 8'h0C);
        bus_write(3'd0, 8'h04);
        check("R3 partial clear", flags, 8'h04);
    endtask

    task automatic t_mask();
        logic [N-1:0] d;
        check("R5 mask zero", {7'd0, comb}, 8'h00);
        bus_write(3'd4, 8'h08);
        check("R5 unselected", {7'd0, comb}, 8'h00);
        bus_write(3'd4, 8'h04);
        check("R5 selected", {7'd0, comb}, 8'h01);
        bus_read(3'd4, d); check("R11 mask readback", d, 8'h04);
        bus_write(3'd1, 8'h04);
        check("R5 drops after clear", {7'd0, comb}, 8'h00);
    endtask

    task automatic t_set_wins();
        bus_write(3'd2, 8'h04);
        @(negedge clk);
        wr = 1'b1; addr = 3'd1; wdata = 8'h04; src[2] = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 3'd0; wdata = '0;
        check("R8 set beats clear", flags, 8'h04);
        bus_write(3'd1, 8'h04);
        check("R8 later clear works", flags, 8'h00);
        set_src(2, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_edge();
        t_level();
        t_pol();
        t_swset();
        t_mask();
        t_set_wins();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule